// File: doc/BRIEF.md
# Interrupt and DMA Request Router

This block forms the request lines seen by an interrupt controller and by a DMA controller. Every line has two candidate drivers: a request from a fixed-function peripheral and a request taken from the programmable logic fabric. A per-line select bit picks one of them. Because any fabric signal can be wired to any line, one peripheral built in the fabric can raise several independent requests.

A second per-line bit chooses how the picked signal is presented. In level mode it passes straight through. In edge mode a rising transition becomes a request pulse one clock wide. On the lowest interrupt lines, the termination outputs of the DMA channels are merged into the fixed-function source, so the completion of a transfer can raise an interrupt.

The reset input is asserted asynchronously and released through a two-stage synchronizer. All request outputs stay low while the synchronized reset is active.

Top module: `irq_drq_router`

## Requirements
- R1: For interrupt line i in level mode, `irq_out[i]` follows the fabric request `fabric_irq[i]` when `irq_sel[i]` is 1 and the fixed source when `irq_sel[i]` is 0, in the same cycle.
- R2: For DMA line j in level mode, `drq_out[j]` follows `fabric_drq[j]` when `drq_sel[j]` is 1 and `fixed_drq[j]` when it is 0, in the same cycle.
- R3: For interrupt lines 0 to N_DRQ-1, the fixed source is the OR of `fixed_irq[i]` and `dma_term[i]`. The termination input has no effect while that line selects the fabric.
- R4: In edge mode (`*_edge[i]` = 1), a rising transition of the selected source drives the output high from that change until the next rising clock edge, which is exactly one clock cycle for inputs that change between edges.
- R5: In edge mode, a selected source that is held high or that falls produces no output.
- R6: The edge history is cleared by reset. A selected source in edge mode that is already high when reset ends yields one pulse, in the first cycle after the synchronized release.
- R7: While `rst_n` is low, and up to the second rising clock edge after it rises, every output is 0.
- R8: The source that is not selected has no effect on the line's output, in either mode.
- R9: The edge history records the selected source in both modes. Turning edge mode on while the source is high gives no pulse. Switching the select from a low source to a high source in edge mode gives a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_sel | input | N_IRQ | Per interrupt line: 1 selects the fabric request, 0 the fixed source |
| irq_edge | input | N_IRQ | Per interrupt line: 1 edge mode, 0 level mode |
| drq_sel | input | N_DRQ | Per DMA line: 1 selects the fabric request, 0 the fixed request |
| drq_edge | input | N_DRQ | Per DMA line: 1 edge mode, 0 level mode |
| fixed_irq | input | N_IRQ | Fixed-function peripheral interrupt requests |
| fabric_irq | input | N_IRQ | Interrupt requests from the programmable fabric |
| dma_term | input | N_DRQ | DMA channel termination outputs, merged into fixed interrupt sources |
| fixed_drq | input | N_DRQ | Fixed-function DMA requests |
| fabric_drq | input | N_DRQ | DMA requests from the programmable fabric |
| irq_out | output | N_IRQ | Request lines to the interrupt controller |
| drq_out | output | N_DRQ | Request lines to the DMA controller |

## Verification
The only internal state is one history bit per line plus the reset synchronizer. A wrong history bit therefore shows up in the same cycle as a missing pulse, an extra pulse on a held-high source, or a pulse longer than one cycle, and nothing remains of the error after the next clock edge. The bench drives every line through both selects and both modes and checks the pulse in the cycle of the rise and the one after it. A faulty source merge, including the termination merge, is visible immediately in level mode. A fault in the reset synchronizer changes which of the first cycles after release carries the pulse.

// File: rtl/irq_drq_pkg.sv
package irq_drq_pkg;

  localparam int unsigned IRQ_LINES_DEF = 8;
  localparam int unsigned DRQ_LINES_DEF = 4;

  typedef struct packed {
    logic use_fabric;
    logic edge_mode;
  } line_cfg_t;

endpackage

// File: rtl/rst_sync_n.sv
module rst_sync_n #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_s_n = sync_q[STAGES-1];

endmodule

// File: rtl/req_src_mux.sv
module req_src_mux (
  input  logic use_fabric,
  input  logic fixed_req,
  input  logic fabric_req,
  output logic picked
);

  always_comb begin
    if (use_fabric) begin
      picked = fabric_req;
    end else begin
      picked = fixed_req;
    end
  end

endmodule

// File: rtl/req_edge_gen.sv
module req_edge_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_mode,
  input  logic din,
  output logic dout
);

  logic hist_q;
  logic hist_d;
  logic hist_en;
  logic shaped;

  // history follows the selected source in every mode
  always_comb begin
    hist_en = 1'b1;
    hist_d  = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= 1'b0;
    end else if (hist_en) begin
      hist_q <= hist_d;
    end
  end

  always_comb begin
    if (edge_mode) begin
      shaped = din & ~hist_q;
    end else begin
      shaped = din;
    end
    dout = shaped & rst_n;
  end

endmodule

// File: rtl/irq_drq_router.sv
module irq_drq_router
  import irq_drq_pkg::*;
#(
  parameter int unsigned N_IRQ = IRQ_LINES_DEF,
  parameter int unsigned N_DRQ = DRQ_LINES_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_sel,
  input  logic [N_IRQ-1:0] irq_edge,
  input  logic [N_DRQ-1:0] drq_sel,
  input  logic [N_DRQ-1:0] drq_edge,
  input  logic [N_IRQ-1:0] fixed_irq,
  input  logic [N_IRQ-1:0] fabric_irq,
  input  logic [N_DRQ-1:0] dma_term,
  input  logic [N_DRQ-1:0] fixed_drq,
  input  logic [N_DRQ-1:0] fabric_drq,
  output logic [N_IRQ-1:0] irq_out,
  output logic [N_DRQ-1:0] drq_out
);

  // termination lines fold onto the lowest interrupt lines
  localparam int unsigned N_TERM = (N_DRQ < N_IRQ) ? N_DRQ : N_IRQ;

  logic             rst_s_n;
  logic [N_IRQ-1:0] irq_fix_src;
  logic [N_IRQ-1:0] irq_pick;
  logic [N_DRQ-1:0] drq_pick;
  line_cfg_t        irq_cfg [N_IRQ];
  line_cfg_t        drq_cfg [N_DRQ];

  rst_sync_n #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
    if (i < N_TERM) begin : g_term
      assign irq_fix_src[i] = fixed_irq[i] | dma_term[i];
    end else begin : g_plain
      assign irq_fix_src[i] = fixed_irq[i];
    end

    assign irq_cfg[i] = '{use_fabric: irq_sel[i], edge_mode: irq_edge[i]};

    req_src_mux u_mux (
      .use_fabric (irq_cfg[i].use_fabric),
      .fixed_req  (irq_fix_src[i]),
      .fabric_req (fabric_irq[i]),
      .picked     (irq_pick[i])
    );

    req_edge_gen u_edge (
      .clk       (clk),
      .rst_n     (rst_s_n),
      .edge_mode (irq_cfg[i].edge_mode),
      .din       (irq_pick[i]),
      .dout      (irq_out[i])
    );
  end

  for (genvar j = 0; j < N_DRQ; j++) begin : g_drq
    assign drq_cfg[j] = '{use_fabric: drq_sel[j], edge_mode: drq_edge[j]};

    req_src_mux u_mux (
      .use_fabric (drq_cfg[j].use_fabric),
      .fixed_req  (fixed_drq[j]),
      .fabric_req (fabric_drq[j]),
      .picked     (drq_pick[j])
    );

    req_edge_gen u_edge (
      .clk       (clk),
      .rst_n     (rst_s_n),
      .edge_mode (drq_cfg[j].edge_mode),
      .din       (drq_pick[j]),
      .dout      (drq_out[j])
    );
  end

endmodule

// File: rtl/irq_drq_router_chk.sv
module irq_drq_router_chk #(
  parameter int unsigned N_IRQ = 8,
  parameter int unsigned N_DRQ = 4
) (
  input logic             clk,
  input logic             rst_s_n,
  input logic [N_IRQ-1:0] irq_sel,
  input logic [N_IRQ-1:0] irq_edge,
  input logic [N_DRQ-1:0] drq_sel,
  input logic [N_DRQ-1:0] drq_edge,
  input logic [N_IRQ-1:0] fixed_irq,
  input logic [N_IRQ-1:0] fabric_irq,
  input logic [N_DRQ-1:0] dma_term,
  input logic [N_DRQ-1:0] fixed_drq,
  input logic [N_DRQ-1:0] fabric_drq,
  input logic [N_IRQ-1:0] irq_out,
  input logic [N_DRQ-1:0] drq_out
);

  logic [N_IRQ-1:0] irq_ref;
  logic [N_DRQ-1:0] drq_ref;
  logic             past_ok;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_s_n |-> (irq_out == '0 && drq_out == '0)); // R7

  for (genvar i = 0; i < N_IRQ; i++) begin : g_irq_chk
    if (i < N_DRQ) begin : g_t
      assign irq_ref[i] = irq_sel[i] ? fabric_irq[i] : (fixed_irq[i] | dma_term[i]);
    end else begin : g_n
      assign irq_ref[i] = irq_sel[i] ? fabric_irq[i] : fixed_irq[i];
    end

    AST_IRQ_LEVEL_ROUTE: assert property (@(posedge clk) disable iff (!rst_s_n)
      !irq_edge[i] |-> (irq_out[i] == irq_ref[i])); // R1

    AST_IRQ_PULSE_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_s_n)
      (irq_edge[i] && irq_out[i]) |-> irq_ref[i]); // R4

    AST_IRQ_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_s_n)
      (irq_edge[i] && irq_out[i]) |=>
        (!irq_out[i] || !irq_edge[i] || (irq_sel[i] != $past(irq_sel[i])))); // R4

    AST_IRQ_NO_PULSE_ON_HOLD: assert property (@(posedge clk) disable iff (!rst_s_n)
      (past_ok && irq_edge[i] && $past(irq_ref[i])) |-> !irq_out[i]); // R5
  end

  for (genvar j = 0; j < N_DRQ; j++) begin : g_drq_chk
    assign drq_ref[j] = drq_sel[j] ? fabric_drq[j] : fixed_drq[j];

    AST_DRQ_LEVEL_ROUTE: assert property (@(posedge clk) disable iff (!rst_s_n)
      !drq_edge[j] |-> (drq_out[j] == drq_ref[j])); // R2

    AST_DRQ_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_s_n)
      (drq_edge[j] && drq_out[j]) |=>
        (!drq_out[j] || !drq_edge[j] || (drq_sel[j] != $past(drq_sel[j])))); // R4

    AST_DRQ_NO_PULSE_ON_HOLD: assert property (@(posedge clk) disable iff (!rst_s_n)
      (past_ok && drq_edge[j] && $past(drq_ref[j])) |-> !drq_out[j]); // R5
  end

endmodule

bind irq_drq_router irq_drq_router_chk #(.N_IRQ(N_IRQ), .N_DRQ(N_DRQ)) u_chk (
  .clk        (clk),
  .rst_s_n    (rst_s_n),
  .irq_sel    (irq_sel),
  .irq_edge   (irq_edge),
  .drq_sel    (drq_sel),
  .drq_edge   (drq_edge),
  .fixed_irq  (fixed_irq),
  .fabric_irq (fabric_irq),
  .dma_term   (dma_term),
  .fixed_drq  (fixed_drq),
  .fabric_drq (fabric_drq),
  .irq_out    (irq_out),
  .drq_out    (drq_out)
);

// File: tb/test_irq_drq_router.sv
`timescale 1ns/1ps
module test_irq_drq_router;

  localparam int NI = 8;
  localparam int ND = 4;
  localparam int NV = 7;

  // level-mode vectors: stimulus and expected outputs
  localparam logic [7:0] V_ISEL [NV] = '{8'h00, 8'hFF, 8'hF0, 8'hF0, 8'h00, 8'h0F, 8'h0A};
  localparam logic [7:0] V_IFIX [NV] = '{8'hA5, 8'hA5, 8'h0F, 8'hF0, 8'h00, 8'h00, 8'h40};
  localparam logic [7:0] V_IFAB [NV] = '{8'h3C, 8'h3C, 8'hF0, 8'h0F, 8'hFF, 8'h00, 8'h02};
  localparam logic [3:0] V_TERM [NV] = '{4'h0, 4'h0, 4'h0, 4'h0, 4'h5, 4'hF, 4'h1};
  localparam logic [3:0] V_DSEL [NV] = '{4'h0, 4'hF, 4'h3, 4'h3, 4'h0, 4'hF, 4'h5};
  localparam logic [3:0] V_DFIX [NV] = '{4'h9, 4'h9, 4'hC, 4'h3, 4'h0, 4'hF, 4'hA};
  localparam logic [3:0] V_DFAB [NV] = '{4'h6, 4'h6, 4'h3, 4'hC, 4'hF, 4'h0, 4'h1};
  localparam logic [7:0] V_IEXP [NV] = '{8'hA5, 8'h3C, 8'hFF, 8'h00, 8'h05, 8'h00, 8'h43};
  localparam logic [3:0] V_DEXP [NV] = '{4'h9, 4'h6, 4'hF, 4'h0, 4'h0, 4'h0, 4'hB};

  logic          clk;
  logic          rst_n;
  logic [NI-1:0] irq_sel, irq_edge, fixed_irq, fabric_irq, irq_out;
  logic [ND-1:0] drq_sel, drq_edge, dma_term, fixed_drq, fabric_drq, drq_out;

  int checks;
  int errors;
  bit done;

  irq_drq_router #(.N_IRQ(NI), .N_DRQ(ND)) i_irq_drq_router (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_sel    (irq_sel),
    .irq_edge   (irq_edge),
    .drq_sel    (drq_sel),
    .drq_edge   (drq_edge),
    .fixed_irq  (fixed_irq),
    .fabric_irq (fabric_irq),
    .dma_term   (dma_term),
    .fixed_drq  (fixed_drq),
    .fabric_drq (fabric_drq),
    .irq_out    (irq_out),
    .drq_out    (drq_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic next_cycle();
    @(negedge clk);
  endtask

  task automatic clear_src();
    fixed_irq = '0; fabric_irq = '0; dma_term = '0;
    fixed_drq = '0; fabric_drq = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0;
    irq_sel = '0; drq_sel = '0;
    irq_edge = '1; drq_edge = '1;
    clear_src();
    fixed_irq = '1; fixed_drq = '1;

    // R7: outputs held low during reset and two edges after release
    repeat (3) next_cycle();
    #1 chk("R7 irq in reset", irq_out, 8'h00);
    chk("R7 drq in reset", {4'h0, drq_out}, 8'h00);
    next_cycle();
    rst_n = 1'b1;
    #1 chk("R7 irq at release", irq_out, 8'h00);
    next_cycle();
    #1 chk("R7 irq after first edge", irq_out, 8'h00);
    chk("R7 drq after first edge", {4'h0, drq_out}, 8'h00);
    // R6: cleared history gives one pulse for sources already high
    next_cycle();
    #1 chk("R6 irq post-reset pulse", irq_out, 8'hFF);
    chk("R6 drq post-reset pulse", {4'h0, drq_out}, 8'h0F);
    next_cycle();
    #1 chk("R6 irq pulse ended", irq_out, 8'h00);
    chk("R6 drq pulse ended", {4'h0, drq_out}, 8'h00);

    // R1 R2 R3 R8: level-mode vector table
    irq_edge = '0; drq_edge = '0;
    for (int k = 0; k < NV; k++) begin
      next_cycle();
      irq_sel = V_ISEL[k]; fixed_irq = V_IFIX[k]; fabric_irq = V_IFAB[k];
      dma_term = V_TERM[k];
      drq_sel = V_DSEL[k]; fixed_drq = V_DFIX[k]; fabric_drq = V_DFAB[k];
      #1;
      if (k >= 4) begin
        chk($sformatf("R3 vector %0d irq", k), irq_out, V_IEXP[k]);
      end else if (k == 3) begin
        chk("R8 vector 3 irq", irq_out, V_IEXP[k]);
      end else begin
        chk($sformatf("R1 vector %0d irq", k), irq_out, V_IEXP[k]);
      end
      chk($sformatf("R2 vector %0d drq", k), {4'h0, drq_out}, {4'h0, V_DEXP[k]});
    end

    // R4 R5 R8: edge mode, every interrupt line, both sources
    irq_edge = '1; drq_edge = '1;
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < NI; i++) begin
        next_cycle();
        clear_src();
        irq_sel = (s == 1) ? 8'hFF : 8'h00;
        next_cycle();
        if (s == 1) fabric_irq[i] = 1'b1; else fixed_irq[i] = 1'b1;
        #1 chk($sformatf("R4 irq line %0d src %0d rise", i, s), irq_out, 8'(1 << i));
        next_cycle();
        #1 chk($sformatf("R4 irq line %0d src %0d width", i, s), irq_out, 8'h00);
        if (s == 1) fixed_irq[i] = 1'b1; else fabric_irq[i] = 1'b1;
        #1 chk($sformatf("R8 irq line %0d other src", i), irq_out, 8'h00);
        next_cycle();
        if (s == 1) fabric_irq[i] = 1'b0; else fixed_irq[i] = 1'b0;
        #1 chk($sformatf("R5 irq line %0d fall", i), irq_out, 8'h00);
      end
    end

    // R4 R5 R8: edge mode, every DMA line, both sources
    for (int s = 0; s < 2; s++) begin
      for (int j = 0; j < ND; j++) begin
        next_cycle();
        clear_src();
        drq_sel = (s == 1) ? 4'hF : 4'h0;
        next_cycle();
        if (s == 1) fabric_drq[j] = 1'b1; else fixed_drq[j] = 1'b1;
        #1 chk($sformatf("R4 drq line %0d src %0d rise", j, s), {4'h0, drq_out}, 8'(1 << j));
        next_cycle();
        #1 chk($sformatf("R4 drq line %0d src %0d width", j, s), {4'h0, drq_out}, 8'h00);
        if (s == 1) fixed_drq[j] = 1'b1; else fabric_drq[j] = 1'b1;
        #1 chk($sformatf("R8 drq line %0d other src", j), {4'h0, drq_out}, 8'h00);
        next_cycle();
        #1 chk($sformatf("R5 drq line %0d hold", j), {4'h0, drq_out}, 8'h00);
      end
    end

    // R3: termination input raises an edge-mode pulse on a fixed-source line
    next_cycle();
    clear_src();
    irq_sel = '0;
    next_cycle();
    dma_term[1] = 1'b1;
    #1 chk("R3 term edge pulse", irq_out, 8'h02);
    next_cycle();
    #1 chk("R3 term pulse width", irq_out, 8'h00);

    // R9: history tracks the selected source in level mode
    next_cycle();
    clear_src();
    irq_edge = '0;
    fixed_irq[2] = 1'b1;
    #1 chk("R9 level high", irq_out, 8'h04);
    next_cycle();
    irq_edge[2] = 1'b1;
    #1 chk("R9 edge on while high", irq_out, 8'h00);
    // R9: switching select from low to high source pulses
    next_cycle();
    irq_sel[2] = 1'b1;
    #1 chk("R9 select low source", irq_out, 8'h00);
    next_cycle();
    irq_sel[2] = 1'b0;
    #1 chk("R9 select back to high source", irq_out, 8'h04);
    next_cycle();
    #1 chk("R9 switch pulse width", irq_out, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule